// File: doc/BRIEF.md
# Dual Audio Port Pin Router

This block sits between an audio codec core and the package pins. It connects the core to one of two external processors: one through a primary audio serial port and one through a secondary port. Configuration bits in a small register bank control the routing. They set the direction of the primary word clock and bit clock pins, and they choose the source that drives each clock when it is an output. They also steer serial data into the core and out of the primary data pin.

The secondary word clock has no dedicated pin. It shares several multi-function pins. A select field names the pin that supplies the secondary word clock input. The two bidirectional GPIO pins and the primary data output pin each also have their own function code. A pin only drives the secondary word clock out when its function code asks for it. A GPIO pin only feeds the secondary input path when its function code marks it as a secondary input. Every routing path is combinational. Only the configuration bank is registered.

Top module: `audio_port_router`

## Requirements
- R1: After the asynchronous active-low reset, every configuration field is 0. So `pwclk_oe_o`, `pbclk_oe_o`, `psdout_oe_o` and `gpio_oe_o` are 0, and `core_sdin_o` follows `psdin_i`.
- R2: A write with `cfg_we_i` high updates its register at the rising clock edge, and the outputs reflect it from then on. The register addresses are: 0 clock control, 1 path control, 2 data-pin function, 3 and 4 GPIO0 and GPIO1 function. A write to addresses 5 to 7, or any cycle with `cfg_we_i` low, changes nothing.
- R3: Clock control bit 0 sets the primary word clock direction, 1 for output. When the bit is 1, `pwclk_oe_o` is 1 and `core_wclk_o` equals the driven value. When it is 0, `pwclk_o` is 0 and `core_wclk_o` follows `pwclk_i`.
- R4: Clock control bits [3:2] choose the primary word clock output source: 00 DAC rate clock, 01 ADC rate clock, 10 selected secondary word clock input. Code 11 falls back to the DAC rate clock.
- R5: Clock control bit 1 sets the bit clock direction in the same way, using `pbclk_*` and `core_bclk_o`. Bit 4 chooses its source: 0 internal bit clock, 1 `sec_bclk_i`.
- R6: Path control bit 0 chooses the data into the core: 0 is `psdin_i`, 1 is `sec_sdin_i`.
- R7: Data-pin function bits [2:0] set the primary data output pin. Code 001 drives it, with path control bit 1 choosing the source: 0 is `int_sdout_i`, 1 is `sec_sdin_i`. Code 111 drives the secondary word clock out. Any other code gives `psdout_oe_o` = 0 and `psdout_o` = 0.
- R8: Path control bits [4:2] pick the secondary word clock input pin: 000 GPIO0, 001 SCLK, 010 MISO, 011 data output pin (which reads as 0), 100 GPIO1, 101 to 111 GPI0 to GPI2. A GPIO pin only supplies the value when its function code is 0001. Otherwise the input reads 0.
- R9: Path control bits [6:5] choose the secondary word clock output source: 00 DAC rate clock, 01 ADC rate clock, 10 the primary word clock as seen by the core. Code 11 falls back to the DAC rate clock.
- R10: A GPIO function code (bits [3:0]) of 1001 sets that pin's enable and drives the secondary word clock out. Any other code leaves the enable and the output at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Configuration clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cfg_we_i | input | 1 | Register write enable |
| cfg_addr_i | input | 3 | Register address |
| cfg_wdata_i | input | 8 | Register write data |
| dac_fs_i | input | 1 | DAC sample-rate clock |
| adc_fs_i | input | 1 | ADC sample-rate clock |
| int_bclk_i | input | 1 | Internal bit clock |
| int_sdout_i | input | 1 | Serial output from the core interface |
| sec_bclk_i | input | 1 | Secondary bit clock |
| sec_sdin_i | input | 1 | Secondary serial data input |
| core_wclk_o | output | 1 | Primary word clock as seen by the core |
| core_bclk_o | output | 1 | Primary bit clock as seen by the core |
| core_sdin_o | output | 1 | Serial data into the core |
| core_sec_wclk_o | output | 1 | Selected secondary word clock input |
| pwclk_i | input | 1 | Primary word clock pin input |
| pwclk_o | output | 1 | Primary word clock pin output |
| pwclk_oe_o | output | 1 | Primary word clock pin enable |
| pbclk_i | input | 1 | Primary bit clock pin input |
| pbclk_o | output | 1 | Primary bit clock pin output |
| pbclk_oe_o | output | 1 | Primary bit clock pin enable |
| psdin_i | input | 1 | Primary serial data input pin |
| psdout_o | output | 1 | Primary data output pin value |
| psdout_oe_o | output | 1 | Primary data output pin enable |
| sclk_i | input | 1 | SCLK pin input |
| miso_i | input | 1 | MISO pin input |
| gpi_i | input | 3 | Input-only general pins |
| gpio_i | input | 2 | GPIO pin inputs |
| gpio_o | output | 2 | GPIO pin outputs |
| gpio_oe_o | output | 2 | GPIO pin enables |

## Verification
A configuration write becomes visible one clock edge after the cycle in which `cfg_we_i` is high. The bench drives each write on a falling edge and drops the enable on the next falling edge. It compares outputs only after that falling edge, so every register has been updated by then. All pin-to-pin routing has zero latency. After each change of pin stimulus the bench waits a short settling delay, away from any clock edge, and then compares every output against a model written from the requirements. Sweeps cover every clock-control value, every path-control value, every data-pin function code and a set of GPIO codes, each with several input patterns.

// File: rtl/apr_pkg.sv
package apr_pkg;
  localparam int NUM_GPIO   = 2;
  localparam int GPIO_FN_W  = 4;
  localparam int SDOUT_FN_W = 3;
  localparam int PIN_SEL_W  = 3;

  localparam int ADDR_CLK       = 0;
  localparam int ADDR_PATH      = 1;
  localparam int ADDR_SDOUT     = 2;
  localparam int ADDR_GPIO_BASE = 3;

  localparam logic [1:0] SRC_DAC = 2'b00;
  localparam logic [1:0] SRC_ADC = 2'b01;
  localparam logic [1:0] SRC_XWC = 2'b10;

  localparam logic [PIN_SEL_W-1:0] PIN_GPIO0 = 3'd0;
  localparam logic [PIN_SEL_W-1:0] PIN_SCLK  = 3'd1;
  localparam logic [PIN_SEL_W-1:0] PIN_MISO  = 3'd2;
  localparam logic [PIN_SEL_W-1:0] PIN_SDOUT = 3'd3;
  localparam logic [PIN_SEL_W-1:0] PIN_GPIO1 = 3'd4;
  localparam logic [PIN_SEL_W-1:0] PIN_GPI0  = 3'd5;
  localparam logic [PIN_SEL_W-1:0] PIN_GPI1  = 3'd6;
  localparam logic [PIN_SEL_W-1:0] PIN_GPI2  = 3'd7;

  localparam logic [GPIO_FN_W-1:0]  GFN_SEC_IN  = 4'b0001;
  localparam logic [GPIO_FN_W-1:0]  GFN_SWC_OUT = 4'b1001;
  localparam logic [SDOUT_FN_W-1:0] DFN_DATA    = 3'b001;
  localparam logic [SDOUT_FN_W-1:0] DFN_SWC_OUT = 3'b111;

  typedef struct packed {
    logic                                 pw_out;
    logic                                 pb_out;
    logic [1:0]                           pw_src;
    logic                                 pb_src;
    logic                                 din_sec;
    logic                                 dout_pass;
    logic [PIN_SEL_W-1:0]                 sw_pin;
    logic [1:0]                           sw_src;
    logic [SDOUT_FN_W-1:0]                sdout_fn;
    logic [NUM_GPIO-1:0][GPIO_FN_W-1:0]   gpio_fn;
  } cfg_t;
endpackage

// File: rtl/apr_cfg_regs.sv
module apr_cfg_regs
  import apr_pkg::*;
#(
  parameter int ADDR_W = 3,
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output cfg_t              cfg_o
);
  localparam logic [ADDR_W-1:0] A_CLK   = ADDR_W'(ADDR_CLK);
  localparam logic [ADDR_W-1:0] A_PATH  = ADDR_W'(ADDR_PATH);
  localparam logic [ADDR_W-1:0] A_SDOUT = ADDR_W'(ADDR_SDOUT);

  cfg_t cfg_q;
  logic unused_wdata;
  assign unused_wdata = ^wdata_i[DATA_W-1:7];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q <= '0;
    end else if (we_i) begin
      if (addr_i == A_CLK) begin
        cfg_q.pw_out <= wdata_i[0];
        cfg_q.pb_out <= wdata_i[1];
        cfg_q.pw_src <= wdata_i[3:2];
        cfg_q.pb_src <= wdata_i[4];
      end
      if (addr_i == A_PATH) begin
        cfg_q.din_sec   <= wdata_i[0];
        cfg_q.dout_pass <= wdata_i[1];
        cfg_q.sw_pin    <= wdata_i[4:2];
        cfg_q.sw_src    <= wdata_i[6:5];
      end
      if (addr_i == A_SDOUT) cfg_q.sdout_fn <= wdata_i[SDOUT_FN_W-1:0];
      for (int g = 0; g < NUM_GPIO; g++) begin
        if (addr_i == ADDR_W'(ADDR_GPIO_BASE + g))
          cfg_q.gpio_fn[g] <= wdata_i[GPIO_FN_W-1:0];
      end
    end
  end

  assign cfg_o = cfg_q;
endmodule

// File: rtl/apr_sec_in_sel.sv
module apr_sec_in_sel
  import apr_pkg::*;
(
  input  cfg_t                cfg_i,
  input  logic                sclk_i,
  input  logic                miso_i,
  input  logic [2:0]          gpi_i,
  input  logic [NUM_GPIO-1:0] gpio_i,
  output logic                sec_wclk_o
);
  logic [NUM_GPIO-1:0] gpio_in_q;

  // GPIO feeds the secondary path only when its own code agrees
  for (genvar g = 0; g < NUM_GPIO; g++) begin : g_gate
    assign gpio_in_q[g] = (cfg_i.gpio_fn[g] == GFN_SEC_IN) & gpio_i[g];
  end

  always_comb begin
    unique case (cfg_i.sw_pin)
      PIN_GPIO0: sec_wclk_o = gpio_in_q[0];
      PIN_SCLK:  sec_wclk_o = sclk_i;
      PIN_MISO:  sec_wclk_o = miso_i;
      PIN_SDOUT: sec_wclk_o = 1'b0;
      PIN_GPIO1: sec_wclk_o = gpio_in_q[1];
      PIN_GPI0:  sec_wclk_o = gpi_i[0];
      PIN_GPI1:  sec_wclk_o = gpi_i[1];
      default:   sec_wclk_o = gpi_i[2];
    endcase
  end
endmodule

// File: rtl/apr_clk_route.sv
module apr_clk_route
  import apr_pkg::*;
(
  input  cfg_t cfg_i,
  input  logic dac_fs_i,
  input  logic adc_fs_i,
  input  logic int_bclk_i,
  input  logic sec_bclk_i,
  input  logic sec_wclk_i,
  input  logic sec_sdin_i,
  input  logic pwclk_i,
  input  logic pbclk_i,
  input  logic psdin_i,
  output logic pwclk_o,
  output logic pwclk_oe_o,
  output logic pbclk_o,
  output logic pbclk_oe_o,
  output logic core_wclk_o,
  output logic core_bclk_o,
  output logic core_sdin_o
);
  logic pw_val, pb_val;

  always_comb begin
    case (cfg_i.pw_src)
      SRC_ADC: pw_val = adc_fs_i;
      SRC_XWC: pw_val = sec_wclk_i;
      default: pw_val = dac_fs_i;  // reserved code falls back
    endcase
  end

  assign pb_val      = cfg_i.pb_src ? sec_bclk_i : int_bclk_i;
  assign pwclk_oe_o  = cfg_i.pw_out;
  assign pbclk_oe_o  = cfg_i.pb_out;
  assign pwclk_o     = cfg_i.pw_out & pw_val;
  assign pbclk_o     = cfg_i.pb_out & pb_val;
  assign core_wclk_o = cfg_i.pw_out ? pw_val : pwclk_i;
  assign core_bclk_o = cfg_i.pb_out ? pb_val : pbclk_i;
  assign core_sdin_o = cfg_i.din_sec ? sec_sdin_i : psdin_i;
endmodule

// File: rtl/apr_pin_drive.sv
module apr_pin_drive
  import apr_pkg::*;
(
  input  cfg_t                cfg_i,
  input  logic                dac_fs_i,
  input  logic                adc_fs_i,
  input  logic                core_wclk_i,
  input  logic                int_sdout_i,
  input  logic                sec_sdin_i,
  output logic                psdout_o,
  output logic                psdout_oe_o,
  output logic [NUM_GPIO-1:0] gpio_o,
  output logic [NUM_GPIO-1:0] gpio_oe_o
);
  logic sw_val;

  always_comb begin
    case (cfg_i.sw_src)
      SRC_ADC: sw_val = adc_fs_i;
      SRC_XWC: sw_val = core_wclk_i;
      default: sw_val = dac_fs_i;
    endcase
  end

  always_comb begin
    psdout_oe_o = 1'b0;
    psdout_o    = 1'b0;
    if (cfg_i.sdout_fn == DFN_DATA) begin
      psdout_oe_o = 1'b1;
      psdout_o    = cfg_i.dout_pass ? sec_sdin_i : int_sdout_i;
    end else if (cfg_i.sdout_fn == DFN_SWC_OUT) begin
      psdout_oe_o = 1'b1;
      psdout_o    = sw_val;
    end
  end

  for (genvar g = 0; g < NUM_GPIO; g++) begin : g_gpio
    assign gpio_oe_o[g] = (cfg_i.gpio_fn[g] == GFN_SWC_OUT);
    assign gpio_o[g]    = gpio_oe_o[g] & sw_val;
  end
endmodule

// File: rtl/audio_port_router.sv
module audio_port_router
  import apr_pkg::*;
#(
  parameter int ADDR_W = 3,
  parameter int DATA_W = 8
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                cfg_we_i,
  input  logic [ADDR_W-1:0]   cfg_addr_i,
  input  logic [DATA_W-1:0]   cfg_wdata_i,
  input  logic                dac_fs_i,
  input  logic                adc_fs_i,
  input  logic                int_bclk_i,
  input  logic                int_sdout_i,
  input  logic                sec_bclk_i,
  input  logic                sec_sdin_i,
  output logic                core_wclk_o,
  output logic                core_bclk_o,
  output logic                core_sdin_o,
  output logic                core_sec_wclk_o,
  input  logic                pwclk_i,
  output logic                pwclk_o,
  output logic                pwclk_oe_o,
  input  logic                pbclk_i,
  output logic                pbclk_o,
  output logic                pbclk_oe_o,
  input  logic                psdin_i,
  output logic                psdout_o,
  output logic                psdout_oe_o,
  input  logic                sclk_i,
  input  logic                miso_i,
  input  logic [2:0]          gpi_i,
  input  logic [NUM_GPIO-1:0] gpio_i,
  output logic [NUM_GPIO-1:0] gpio_o,
  output logic [NUM_GPIO-1:0] gpio_oe_o
);
  localparam int LAST_ADDR = ADDR_GPIO_BASE + NUM_GPIO - 1;

  cfg_t cfg;
  logic sec_wclk;

  apr_cfg_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (cfg_we_i),
    .addr_i (cfg_addr_i),
    .wdata_i(cfg_wdata_i),
    .cfg_o  (cfg)
  );

  apr_sec_in_sel u_sec_in (
    .cfg_i     (cfg),
    .sclk_i    (sclk_i),
    .miso_i    (miso_i),
    .gpi_i     (gpi_i),
    .gpio_i    (gpio_i),
    .sec_wclk_o(sec_wclk)
  );

  apr_clk_route u_clk (
    .cfg_i      (cfg),
    .dac_fs_i   (dac_fs_i),
    .adc_fs_i   (adc_fs_i),
    .int_bclk_i (int_bclk_i),
    .sec_bclk_i (sec_bclk_i),
    .sec_wclk_i (sec_wclk),
    .sec_sdin_i (sec_sdin_i),
    .pwclk_i    (pwclk_i),
    .pbclk_i    (pbclk_i),
    .psdin_i    (psdin_i),
    .pwclk_o    (pwclk_o),
    .pwclk_oe_o (pwclk_oe_o),
    .pbclk_o    (pbclk_o),
    .pbclk_oe_o (pbclk_oe_o),
    .core_wclk_o(core_wclk_o),
    .core_bclk_o(core_bclk_o),
    .core_sdin_o(core_sdin_o)
  );

  apr_pin_drive u_drive (
    .cfg_i      (cfg),
    .dac_fs_i   (dac_fs_i),
    .adc_fs_i   (adc_fs_i),
    .core_wclk_i(core_wclk_o),
    .int_sdout_i(int_sdout_i),
    .sec_sdin_i (sec_sdin_i),
    .psdout_o   (psdout_o),
    .psdout_oe_o(psdout_oe_o),
    .gpio_o     (gpio_o),
    .gpio_oe_o  (gpio_oe_o)
  );

  assign core_sec_wclk_o = sec_wclk;

  a_r3_wclk_dir_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_we_i && cfg_addr_i == ADDR_W'(ADDR_CLK) |=> pwclk_oe_o == $past(cfg_wdata_i[0]));

  a_r5_bclk_dir_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_we_i && cfg_addr_i == ADDR_W'(ADDR_CLK) |=> pbclk_oe_o == $past(cfg_wdata_i[1]));

  a_r2_unmapped_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_we_i && int'(cfg_addr_i) > LAST_ADDR |=>
      $stable(pwclk_oe_o) && $stable(pbclk_oe_o) && $stable(psdout_oe_o) && $stable(gpio_oe_o));

  a_r7_sdout_data_code: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_we_i && cfg_addr_i == ADDR_W'(ADDR_SDOUT) && cfg_wdata_i[2:0] == DFN_DATA |=> psdout_oe_o);

  a_r10_gpio0_out_code: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_we_i && cfg_addr_i == ADDR_W'(ADDR_GPIO_BASE) && cfg_wdata_i[3:0] == GFN_SWC_OUT
      |=> gpio_oe_o[0]);

  // R8: a driven GPIO never feeds the secondary input path
  a_r8_gpio0_no_self_feed: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg.sw_pin == PIN_GPIO0 && gpio_oe_o[0] |-> !core_sec_wclk_o);
endmodule

// File: tb/audio_port_router_tb_top.sv
module audio_port_router_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic       we = 1'b0;
  logic [2:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [15:0] st = '0;

  logic core_wclk, core_bclk, core_sdin, core_sec_wclk;
  logic pwclk_o, pwclk_oe, pbclk_o, pbclk_oe, psdout_o, psdout_oe;
  logic [1:0] gpio_o, gpio_oe;

  int vectors = 0;
  int miscompares = 0;
  bit done = 1'b0;

  logic [7:0] c0 = '0, c1 = '0, c2 = '0, g0 = '0, g1 = '0;

  audio_port_router dut_i (
    .clk_i(clk), .rst_ni(rst_n), .cfg_we_i(we), .cfg_addr_i(addr), .cfg_wdata_i(wdata),
    .dac_fs_i(st[0]), .adc_fs_i(st[1]), .int_bclk_i(st[2]), .int_sdout_i(st[3]),
    .sec_bclk_i(st[4]), .sec_sdin_i(st[5]),
    .core_wclk_o(core_wclk), .core_bclk_o(core_bclk), .core_sdin_o(core_sdin),
    .core_sec_wclk_o(core_sec_wclk),
    .pwclk_i(st[6]), .pwclk_o(pwclk_o), .pwclk_oe_o(pwclk_oe),
    .pbclk_i(st[7]), .pbclk_o(pbclk_o), .pbclk_oe_o(pbclk_oe),
    .psdin_i(st[8]), .psdout_o(psdout_o), .psdout_oe_o(psdout_oe),
    .sclk_i(st[9]), .miso_i(st[10]), .gpi_i(st[13:11]),
    .gpio_i(st[15:14]), .gpio_o(gpio_o), .gpio_oe_o(gpio_oe)
  );

  task automatic chk(input string tag, input logic act, input logic exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s act=%b exp=%b cfg=%h/%h/%h/%h/%h st=%h", tag, act, exp, c0, c1, c2, g0, g1, st);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    we = 1'b1; addr = a; wdata = d;
    case (a)
      3'd0: c0 = d;
      3'd1: c1 = d;
      3'd2: c2 = d;
      3'd3: g0 = d;
      3'd4: g1 = d;
      default: ;
    endcase
  endtask

  task automatic idle();
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic check_all();
    logic sin, pw, pb, cw, cb, sw, e_do, e_doe;
    logic [1:0] go, goe;
    #1;
    case (c1[4:2])
      3'd0: sin = (g0[3:0] == 4'b0001) & st[14];
      3'd1: sin = st[9];
      3'd2: sin = st[10];
      3'd3: sin = 1'b0;
      3'd4: sin = (g1[3:0] == 4'b0001) & st[15];
      3'd5: sin = st[11];
      3'd6: sin = st[12];
      default: sin = st[13];
    endcase
    pw = (c0[3:2] == 2'b01) ? st[1] : (c0[3:2] == 2'b10) ? sin : st[0];
    pb = c0[4] ? st[4] : st[2];
    cw = c0[0] ? pw : st[6];
    cb = c0[1] ? pb : st[7];
    sw = (c1[6:5] == 2'b01) ? st[1] : (c1[6:5] == 2'b10) ? cw : st[0];
    e_doe = (c2[2:0] == 3'b001) || (c2[2:0] == 3'b111);
    e_do  = (c2[2:0] == 3'b001) ? (c1[1] ? st[5] : st[3]) : (c2[2:0] == 3'b111) ? sw : 1'b0;
    goe = {g1[3:0] == 4'b1001, g0[3:0] == 4'b1001};
    go  = goe & {sw, sw};
    chk("R8 core_sec_wclk", core_sec_wclk, sin);
    chk("R3 pwclk_oe", pwclk_oe, c0[0]);
    chk("R4 pwclk_o", pwclk_o, c0[0] & pw);
    chk("R3 core_wclk", core_wclk, cw);
    chk("R5 pbclk_oe", pbclk_oe, c0[1]);
    chk("R5 pbclk_o", pbclk_o, c0[1] & pb);
    chk("R5 core_bclk", core_bclk, cb);
    chk("R6 core_sdin", core_sdin, c1[0] ? st[5] : st[8]);
    chk("R7 psdout_oe", psdout_oe, e_doe);
    chk("R7 psdout_o", psdout_o, e_do);
    chk("R9 R10 gpio_oe0", gpio_oe[0], goe[0]);
    chk("R9 R10 gpio_oe1", gpio_oe[1], goe[1]);
    chk("R9 R10 gpio_o0", gpio_o[0], go[0]);
    chk("R9 R10 gpio_o1", gpio_o[1], go[1]);
  endtask

  task automatic step_st();
    st = {st[14:0], st[15] ^ st[13] ^ st[12] ^ st[10]};
  endtask

  task automatic summary();
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
    end
  end

  initial begin
    logic [7:0] gcode [4];
    gcode[0] = 8'h00; gcode[1] = 8'h01; gcode[2] = 8'h09; gcode[3] = 8'h05;
    st = 16'hACE1;
    repeat (3) @(negedge clk);
    // R1: reset state
    for (int k = 0; k < 4; k++) begin check_all(); step_st(); end
    rst_n = 1'b1;
    @(negedge clk);
    for (int k = 0; k < 4; k++) begin check_all(); step_st(); end

    // R3 R4 R5: every clock-control value, secondary input from SCLK
    wr(3'd1, 8'h04); idle();
    for (int v = 0; v < 32; v++) begin
      wr(3'd0, 8'(v)); idle();
      for (int k = 0; k < 16; k++) begin check_all(); step_st(); end
    end

    // R6 R7 R8 R9 R10: path, data-pin and GPIO code sweep
    for (int p = 0; p < 128; p++) begin
      wr(3'd1, 8'(p)); wr(3'd0, 8'(p) ^ 8'h0B); idle();
      for (int f = 0; f < 8; f++) begin
        wr(3'd2, 8'(f)); idle();
        for (int gc = 0; gc < 16; gc++) begin
          wr(3'd3, gcode[gc % 4]); wr(3'd4, gcode[gc / 4]); idle();
          for (int k = 0; k < 3; k++) begin check_all(); step_st(); end
        end
      end
    end

    // R2: unmapped addresses and writes with enable low change nothing
    wr(3'd0, 8'h00); wr(3'd1, 8'h00); wr(3'd2, 8'h00); wr(3'd3, 8'h00); wr(3'd4, 8'h00); idle();
    for (int a = 5; a < 8; a++) begin
      wr(3'(a), 8'hFF); idle();
      for (int k = 0; k < 4; k++) begin check_all(); step_st(); end
    end
    @(negedge clk);
    addr = 3'd0; wdata = 8'hFF;
    @(negedge clk);
    addr = 3'd2; wdata = 8'h07;
    @(negedge clk);
    for (int k = 0; k < 4; k++) begin check_all(); step_st(); end

    // R1: reset clears a populated bank
    wr(3'd0, 8'h1F); wr(3'd1, 8'h7F); wr(3'd2, 8'h07); wr(3'd3, 8'h09); wr(3'd4, 8'h09); idle();
    check_all();
    rst_n = 1'b0;
    c0 = '0; c1 = '0; c2 = '0; g0 = '0; g1 = '0;
    for (int k = 0; k < 4; k++) begin check_all(); step_st(); end
    rst_n = 1'b1;
    @(negedge clk);
    check_all();

    done = 1'b1;
    summary();
    $finish;
  end
endmodule